// File: doc/BRIEF.md
# Branch Condition and Counter Unit

This block makes the decision for one conditional branch and computes what follows from it. The caller supplies the condition bit selected by decode, the four-bit branch control field, the link and absolute-address flags, a 14-bit word displacement, the address of the current instruction and the current counter value. The block returns three results in the same cycle: the next instruction address, the counter value after any decrement, and whether the link register is written and with what value.

The counter decrement can depend on the condition outcome. A counter-test flag cancels the decrement when the condition result differs from an inversion flag. A separate link-update flag allows a link write on a branch that is not taken. Instructions are 8 bytes long, so a fall-through advances the address by 8. The returned link value is the current address plus 4.

The unit keeps its own copies of the counter and the link register. Both copies are loaded from the computed results on a cycle where the valid strobe is high.

Top module: `branch_ctr_unit`

## Requirements
- R1: The condition passes when `bo_ctl[3]` (ignore condition) is 1, or when `cond_bit` equals `bo_ctl[2]` (expected value).
- R2: When `bo_ctl[1]` (skip counter) is 0, `ctr_upd` is `ctr_in - 1` with 64-bit wraparound, so 0 becomes all ones. The decrement is cancelled when `ctr_test` is 1 and (condition result XOR `ctr_inv`) is 1. In every other case `ctr_upd` equals `ctr_in`.
- R3: The counter check passes when `bo_ctl[1]` is 1, or when (`ctr_upd` is nonzero) XOR `bo_ctl[0]` is 1. The check uses the updated value, not `ctr_in`.
- R4: A branch is taken only when both the counter check and the condition pass. The target is `{bd, 2'b00}` sign-extended to 64 bits. With `aa`=1 the target is used as an absolute address; with `aa`=0 it is added to `cia`.
- R5: When the branch is not taken, `next_ia` is `cia + 8`.
- R6: `lr_we` is `lk AND (lru OR taken)`, and `lr_val` is `cia + 4`.
- R7: On a clock edge with `in_valid`=1, `ctr_q` loads `ctr_upd`, and `lr_q` loads `lr_val` if `lr_we` is 1. When `in_valid`=0, both registers hold their values.
- R8: An active-low reset clears `ctr_q` and `lr_q` to zero.
- R9: When `mode64`=0, the nonzero test in R3 looks only at `ctr_upd[31:0]`. When `mode64`=1, it looks at all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Commit strobe for the internal registers |
| cond_bit | input | 1 | Selected condition bit |
| bo_ctl | input | 4 | [3] ignore condition, [2] expected condition, [1] skip counter, [0] branch on zero |
| lk | input | 1 | Request a link write |
| aa | input | 1 | Target is absolute |
| bd | input | 14 | Signed word displacement |
| cia | input | 64 | Current instruction address |
| mode64 | input | 1 | 1: 64-bit counter check, 0: low 32 bits |
| lru | input | 1 | Allow a link write on a branch that is not taken |
| ctr_test | input | 1 | Make the decrement depend on the condition |
| ctr_inv | input | 1 | Invert the dependency from ctr_test |
| ctr_in | input | 64 | Current counter value |
| next_ia | output | 64 | Next instruction address |
| ctr_upd | output | 64 | Counter after the optional decrement |
| lr_we | output | 1 | Link write enable |
| lr_val | output | 64 | Link write value |
| ctr_q | output | 64 | Registered counter |
| lr_q | output | 64 | Registered link value |

## Verification
The hardest case to reach from the ports is a 32-bit counter check on a value whose low half becomes zero while its upper half stays nonzero. The stimulus sets `ctr_in` to 0x1_00000001, so the decrement produces exactly that value. It then repeats the same item with `mode64` at 1, and the branch decision flips. Cancelled decrements are reached by pairing `ctr_test` with both values of `ctr_inv` against both condition outcomes. Wraparound is reached with a counter input of zero.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
   // Positions inside the branch control field
   localparam int unsigned BO_IGN_COND = 3;
   localparam int unsigned BO_EXP_COND = 2;
   localparam int unsigned BO_NO_CTR   = 1;
   localparam int unsigned BO_ON_ZERO  = 0;
   localparam int unsigned BO_W        = 4;

   typedef struct packed {
      logic cond_ok;
      logic ctr_ok;
      logic taken;
   } bcu_verdict_t;
endpackage

// File: rtl/bcu_cond.sv
module bcu_cond (
   input  logic cond_bit,
   input  logic ign_cond,
   input  logic exp_cond,
   output logic cond_ok
);
   always_comb begin
      cond_ok = ign_cond | ~(cond_bit ^ exp_cond);
   end
endmodule

// File: rtl/bcu_ctr.sv
module bcu_ctr #(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned HALF         = 32,
   parameter bit          SUPPORT_HALF = 1'b1
) (
   input  logic [XLEN-1:0] ctr_in,
   input  logic            no_ctr,
   input  logic            on_zero,
   input  logic            ctr_test,
   input  logic            ctr_inv,
   input  logic            cond_ok,
   input  logic            mode64,
   output logic [XLEN-1:0] ctr_upd,
   output logic            ctr_ok
);
   localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

   logic dec_req;
   logic dec_cancel;
   logic nonzero;

   always_comb begin
      dec_cancel = ctr_test & (cond_ok ^ ctr_inv);
      dec_req    = ~no_ctr & ~dec_cancel;
      ctr_upd    = dec_req ? (ctr_in - ONE) : ctr_in;
   end

   generate
      if (SUPPORT_HALF) begin : g_dual_width
         logic nz_full;
         logic nz_low;
         always_comb begin
            nz_full = |ctr_upd;
            nz_low  = |ctr_upd[HALF-1:0];
            nonzero = mode64 ? nz_full : nz_low;
         end
      end else begin : g_full_only
         logic unused_mode;
         always_comb begin
            unused_mode = mode64;
            nonzero     = |ctr_upd;
         end
      end
   endgenerate

   always_comb begin
      ctr_ok = no_ctr | (nonzero ^ on_zero);
   end
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned BD_W       = 14,
   parameter int unsigned STEP_BYTES = 8,
   parameter int unsigned LINK_BYTES = 4
) (
   input  logic [BD_W-1:0] bd,
   input  logic            aa,
   input  logic [XLEN-1:0] cia,
   input  logic            taken,
   output logic [XLEN-1:0] next_ia,
   output logic [XLEN-1:0] link_val
);
   localparam int unsigned    EXT_W = XLEN - BD_W - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);
   localparam logic [XLEN-1:0] LINK = XLEN'(LINK_BYTES);

   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] target;

   always_comb begin
      disp     = {{EXT_W{bd[BD_W-1]}}, bd, 2'b00};
      target   = aa ? disp : (cia + disp);
      next_ia  = taken ? target : (cia + STEP);
      link_val = cia + LINK;
   end
endmodule

// File: rtl/branch_ctr_unit.sv
module branch_ctr_unit
   import bcu_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned HALF         = 32,
   parameter int unsigned BD_W         = 14,
   parameter int unsigned STEP_BYTES   = 8,
   parameter int unsigned LINK_BYTES   = 4,
   parameter bit          SUPPORT_HALF = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            cond_bit,
   input  logic [3:0]      bo_ctl,
   input  logic            lk,
   input  logic            aa,
   input  logic [13:0]     bd,
   input  logic [63:0]     cia,
   input  logic            mode64,
   input  logic            lru,
   input  logic            ctr_test,
   input  logic            ctr_inv,
   input  logic [63:0]     ctr_in,
   output logic [63:0]     next_ia,
   output logic [63:0]     ctr_upd,
   output logic            lr_we,
   output logic [63:0]     lr_val,
   output logic [63:0]     ctr_q,
   output logic [63:0]     lr_q
);
   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("branch_ctr_unit: XLEN must match the 64-bit port width");
      end
      if (BD_W != 14) begin : g_bad_bd
         $error("branch_ctr_unit: BD_W must match the 14-bit port width");
      end
      if (SUPPORT_HALF && (HALF == 0 || HALF >= XLEN)) begin : g_bad_half
         $error("branch_ctr_unit: HALF must lie between 1 and XLEN-1");
      end
      if (STEP_BYTES == 0 || LINK_BYTES == 0) begin : g_bad_step
         $error("branch_ctr_unit: address steps must be nonzero");
      end
   endgenerate

   bcu_verdict_t verdict;
   logic         cond_ok_w;
   logic         ctr_ok_w;

   bcu_cond u_cond (
      .cond_bit (cond_bit),
      .ign_cond (bo_ctl[BO_IGN_COND]),
      .exp_cond (bo_ctl[BO_EXP_COND]),
      .cond_ok  (cond_ok_w)
   );

   bcu_ctr #(
      .XLEN         (XLEN),
      .HALF         (HALF),
      .SUPPORT_HALF (SUPPORT_HALF)
   ) u_ctr (
      .ctr_in   (ctr_in),
      .no_ctr   (bo_ctl[BO_NO_CTR]),
      .on_zero  (bo_ctl[BO_ON_ZERO]),
      .ctr_test (ctr_test),
      .ctr_inv  (ctr_inv),
      .cond_ok  (cond_ok_w),
      .mode64   (mode64),
      .ctr_upd  (ctr_upd),
      .ctr_ok   (ctr_ok_w)
   );

   always_comb begin
      verdict.cond_ok = cond_ok_w;
      verdict.ctr_ok  = ctr_ok_w;
      verdict.taken   = cond_ok_w & ctr_ok_w;
   end

   bcu_target #(
      .XLEN       (XLEN),
      .BD_W       (BD_W),
      .STEP_BYTES (STEP_BYTES),
      .LINK_BYTES (LINK_BYTES)
   ) u_tgt (
      .bd       (bd),
      .aa       (aa),
      .cia      (cia),
      .taken    (verdict.taken),
      .next_ia  (next_ia),
      .link_val (lr_val)
   );

   always_comb begin
      lr_we = lk & (lru | verdict.taken);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr_q <= '0;
         lr_q  <= '0;
      end else if (in_valid) begin
         ctr_q <= ctr_upd;
         if (lr_we) begin
            lr_q <= lr_val;
         end
      end
   end
endmodule

// File: rtl/bcu_chk.sv
module bcu_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        cond_bit,
   input logic [3:0]  bo_ctl,
   input logic        lk,
   input logic [63:0] cia,
   input logic [63:0] ctr_in,
   input logic [63:0] next_ia,
   input logic [63:0] ctr_upd,
   input logic        lr_we,
   input logic [63:0] ctr_q,
   input logic [63:0] lr_q,
   input logic [63:0] lr_val
);
   AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ctr_q == $past(ctr_upd)); // R7
   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(ctr_q)); // R7
   AST_LR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && lr_we) |=> $stable(lr_q)); // R7
   AST_LR_NEEDS_LK: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> lk); // R6
   AST_SKIP_KEEPS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
      bo_ctl[1] |-> ctr_upd == ctr_in); // R2
   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_upd == ctr_in) || (ctr_upd == ctr_in - 64'd1)); // R2
   AST_FAIL_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!bo_ctl[3] && (cond_bit != bo_ctl[2])) |-> next_ia == cia + 64'd8); // R5
endmodule

bind branch_ctr_unit bcu_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .cond_bit (cond_bit),
   .bo_ctl   (bo_ctl),
   .lk       (lk),
   .cia      (cia),
   .ctr_in   (ctr_in),
   .next_ia  (next_ia),
   .ctr_upd  (ctr_upd),
   .lr_we    (lr_we),
   .ctr_q    (ctr_q),
   .lr_q     (lr_q),
   .lr_val   (lr_val)
);

// File: tb/branch_ctr_unit_test.sv
`timescale 1ns/1ps
module branch_ctr_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        cond_bit = 1'b0;
   logic [3:0]  bo_ctl = '0;
   logic        lk = 1'b0, aa = 1'b0, mode64 = 1'b1, lru = 1'b0;
   logic        ctr_test = 1'b0, ctr_inv = 1'b0;
   logic [13:0] bd = '0;
   logic [63:0] cia = '0, ctr_in = '0;
   logic [63:0] next_ia, ctr_upd, lr_val, ctr_q, lr_q;
   logic        lr_we;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [63:0] nia;
      logic [63:0] cupd;
      logic        we;
      logic [63:0] lrv;
      logic [63:0] cq;
      logic [63:0] lq;
      string       tag;
   } item_t;

   item_t sb[$];
   logic [63:0] m_ctr = '0;
   logic [63:0] m_lr = '0;

   always #5 clk = ~clk;

   branch_ctr_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_bit(cond_bit),
      .bo_ctl(bo_ctl), .lk(lk), .aa(aa), .bd(bd), .cia(cia), .mode64(mode64),
      .lru(lru), .ctr_test(ctr_test), .ctr_inv(ctr_inv), .ctr_in(ctr_in),
      .next_ia(next_ia), .ctr_upd(ctr_upd), .lr_we(lr_we), .lr_val(lr_val),
      .ctr_q(ctr_q), .lr_q(lr_q)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: applies one item at the falling edge and queues the expectation
   task automatic drive(input logic v, input logic c, input logic [3:0] bo,
                        input logic l, input logic a, input logic [13:0] d,
                        input logic [63:0] pc, input logic m, input logic u,
                        input logic t, input logic inv, input logic [63:0] ctr,
                        input string tag);
      item_t it;
      logic cok, dec, nz, cok2, tk;
      logic [63:0] upd, disp;
      @(negedge clk);
      in_valid = v; cond_bit = c; bo_ctl = bo; lk = l; aa = a; bd = d;
      cia = pc; mode64 = m; lru = u; ctr_test = t; ctr_inv = inv; ctr_in = ctr;
      cok  = bo[3] | (c == bo[2]);                         // R1
      dec  = !bo[1] && !(t && (cok ^ inv));                // R2
      upd  = dec ? ctr - 64'd1 : ctr;
      nz   = m ? (upd != 0) : (upd[31:0] != 0);            // R9
      cok2 = bo[1] | (nz ^ bo[0]);                         // R3
      tk   = cok & cok2;                                   // R4
      disp = {{48{d[13]}}, d, 2'b00};
      it.nia  = tk ? (a ? disp : pc + disp) : pc + 64'd8;  // R5
      it.cupd = upd;
      it.we   = l & (u | tk);                              // R6
      it.lrv  = pc + 64'd4;
      if (v) begin                                         // R7
         m_ctr = upd;
         if (it.we) m_lr = it.lrv;
      end
      it.cq = m_ctr;
      it.lq = m_lr;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: 2 ns after each rising edge, compares the oldest expectation
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            check({e.tag, " next_ia"}, next_ia, e.nia);
            check("R2 ctr_upd", ctr_upd, e.cupd);
            check("R6 lr_we", {63'd0, lr_we}, {63'd0, e.we});
            check("R6 lr_val", lr_val, e.lrv);
            check("R7 ctr_q", ctr_q, e.cq);
            check("R7 lr_q", lr_q, e.lq);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R8 ctr_q reset", ctr_q, 64'd0);
      check("R8 lr_q reset", lr_q, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 R4: unconditional, counter skipped, relative forward target
      drive(1, 0, 4'b1010, 1, 0, 14'd16, 64'h1000, 1, 0, 0, 0, 64'd7, "R1 R4");
      // R5 R6: condition fails, lk without lru gives no link write
      drive(1, 1, 4'b0010, 1, 0, 14'd16, 64'h2000, 1, 0, 0, 0, 64'd7, "R5");
      // R6: lru allows a link write on a branch that is not taken
      drive(1, 1, 4'b0010, 1, 0, 14'd16, 64'h3000, 1, 1, 0, 0, 64'd7, "R6");
      // R1: condition matches the expected value of 1
      drive(1, 1, 4'b0110, 0, 0, 14'h3FFC, 64'h4000, 1, 0, 0, 0, 64'd0, "R1");
      // R4: absolute target, negative displacement
      drive(1, 0, 4'b1010, 0, 1, 14'h3FFF, 64'h5000, 1, 0, 0, 0, 64'd0, "R4 abs");
      // R2 R3: decrement 5 -> 4, branch on nonzero
      drive(1, 0, 4'b1000, 1, 0, 14'd2, 64'h6000, 1, 0, 0, 0, 64'd5, "R3 nz");
      // R3: decrement 1 -> 0 uses the updated value, not taken
      drive(1, 0, 4'b1000, 1, 0, 14'd2, 64'h7000, 1, 0, 0, 0, 64'd1, "R3 upd");
      // R2: wraparound from zero
      drive(1, 0, 4'b1000, 0, 0, 14'd2, 64'h8000, 1, 0, 0, 0, 64'd0, "R2 wrap");
      // R2: ctr_test with cond passing, no inversion -> cancelled
      drive(1, 0, 4'b1001, 0, 0, 14'd2, 64'h9000, 1, 0, 1, 0, 64'd3, "R2 cancel");
      // R2: ctr_test with inversion and cond passing -> decrement
      drive(1, 0, 4'b1001, 0, 0, 14'd2, 64'h9100, 1, 0, 1, 1, 64'd3, "R2 inv");
      // R2: ctr_test with inversion and cond failing -> cancelled
      drive(1, 1, 4'b0001, 0, 0, 14'd2, 64'h9200, 1, 0, 1, 1, 64'd3, "R2 inv fail");
      // R2: ctr_test without inversion and cond failing -> decrement
      drive(1, 1, 4'b0001, 0, 0, 14'd2, 64'h9300, 1, 0, 1, 0, 64'd3, "R2 fail dec");
      // R9: low half becomes zero, branch on zero, 32-bit mode -> taken
      drive(1, 0, 4'b1001, 0, 0, 14'd64, 64'hA000, 0, 0, 0, 0, 64'h1_0000_0001, "R9 m32");
      // R9: same item in 64-bit mode -> not taken
      drive(1, 0, 4'b1001, 0, 0, 14'd64, 64'hA000, 1, 0, 0, 0, 64'h1_0000_0001, "R9 m64");
      // R7: strobe low, registers must hold while inputs change
      drive(0, 0, 4'b1000, 1, 0, 14'd2, 64'hB000, 1, 1, 0, 0, 64'd99, "R7 hold");
      drive(0, 1, 4'b0000, 1, 1, 14'd9, 64'hC000, 0, 1, 0, 0, 64'd0, "R7 hold");
      for (int i = 0; i < 300; i++) begin
         drive($urandom_range(1, 0), $urandom_range(1, 0), 4'($urandom),
               $urandom_range(1, 0), $urandom_range(1, 0), 14'($urandom),
               {$urandom, $urandom}, $urandom_range(1, 0), $urandom_range(1, 0),
               $urandom_range(1, 0), $urandom_range(1, 0),
               (i % 4 == 0) ? 64'($urandom_range(2, 0)) : {$urandom, $urandom},
               "R4 R5 rand");
      end
      @(negedge clk);
      in_valid = 1'b0;
      while (sb.size() > 0) @(posedge clk);
      #3;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule